// File: doc/BRIEF.md
# Serial Graphic Display Command Receiver

This block is the controller side of a write-only serial link to a 4-bit-per-pixel graphic panel. A host frames bytes with an active-low chip select and drives serial data and a serial clock. A data/command select line marks each byte as either a command or pixel data. The receiver runs on its own system clock. It oversamples the link pins through synchronizers and samples data on each falling serial-clock edge.

Bytes sent with the select line low go to a parser for fixed-length command sequences. The parser holds a column window, a row window, a contrast level and a drive-current range. Bytes sent with the select line high become single-cycle writes on a display-RAM port. Each write carries one byte holding two pixels. A pointer walks the current window and advances by one byte after every write, so the host can refresh any rectangle without sending addresses.

Top module: `oled_cmd_rx`

## Requirements
- R1: While `cs_n` is low, a byte is assembled from eight `sdin` bits sampled on falling `sclk` edges, first bit received becoming bit 7; `dc` is taken on the eighth falling edge.
- R2: While `cs_n` is high the bit count is held at zero and `sclk` is ignored, so a byte left incomplete when `cs_n` rises is dropped and the next byte frames from its first bit.
- R3: Each byte with `dc` high produces exactly one `ram_we` pulse of one cycle, with `ram_wdata` equal to the byte (bits 7:4 the left pixel, bits 3:0 the right) and `ram_addr` equal to row pointer times 64 plus column pointer.
- R4: After reset the column window is 0..63, the row window is 0..79, contrast is 0x40, `irange` is 0, both pointers are 0, and `ram_we` is low.
- R5: Command byte 0x15 followed by two parameter bytes sets column start and column end from bits 5:0 of each, and loads the column pointer with the new start.
- R6: Command byte 0x75 followed by two parameter bytes sets row start and row end; a parameter above 79 is stored as 79; the row pointer is loaded with the new start.
- R7: Command byte 0x81 followed by one parameter byte sets contrast to bits 6:0 of that byte.
- R8: Single command bytes 0x84, 0x85, 0x86 set `irange` to 0 (quarter), 1 (half), 2 (full).
- R9: After each data byte the column pointer increments; at the column end (or column 63) it returns to column start and the row pointer increments; at the row end (or row 79) the row pointer returns to row start.
- R10: A command-marked byte that arrives while parameters are still owed is consumed as the next parameter, not decoded as an opcode.
- R11: Any other command code leaves all window, contrast, range and pointer state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Link select, active low |
| sclk | input | 1 | Serial clock from host |
| sdin | input | 1 | Serial data from host |
| dc | input | 1 | High for pixel data, low for command bytes |
| ram_we | output | 1 | One-cycle display-RAM write strobe |
| ram_addr | output | 13 | Display-RAM byte address |
| ram_wdata | output | 8 | Display-RAM byte, two 4-bit pixels |
| col_start | output | 6 | Column window start |
| col_end | output | 6 | Column window end |
| row_start | output | 7 | Row window start |
| row_end | output | 7 | Row window end |
| contrast | output | 7 | Contrast level |
| irange | output | 2 | Current range: 0 quarter, 1 half, 2 full |

## Verification
A wrong bit count or a lost partial-byte clear shows up on the very next data write, as a shifted `ram_wdata` value. A parser left in the wrong state turns later data into wrong window values, or makes configuration outputs change when they should not. Both are visible a few cycles after the byte that caused them. A pointer fault is silent until the next data byte, and then appears as a wrong `ram_addr`. The bench therefore follows every window change with enough writes to cross both the column wrap and the row wrap.

// File: rtl/oled_rx_pkg.sv
package oled_rx_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_COL_A,
        PS_COL_B,
        PS_ROW_A,
        PS_ROW_B,
        PS_LEVEL
    } parse_e;

    localparam logic [1:0] IR_QUARTER = 2'd0;
    localparam logic [1:0] IR_HALF    = 2'd1;
    localparam logic [1:0] IR_FULL    = 2'd2;

    localparam logic [7:0] OP_COLWIN  = 8'h15;
    localparam logic [7:0] OP_ROWWIN  = 8'h75;
    localparam logic [7:0] OP_LEVEL   = 8'h81;
    localparam logic [7:0] OP_IR_Q    = 8'h84;
    localparam logic [7:0] OP_IR_H    = 8'h85;
    localparam logic [7:0] OP_IR_F    = 8'h86;

    localparam logic [6:0] LEVEL_RST  = 7'h40;

endpackage

// File: rtl/oled_rx_sync.sv
module oled_rx_sync #(
    parameter int          N       = 4,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stg_q [STAGES];
    logic [N-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/oled_rx_shift.sv
module oled_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdin_s,
    input  logic              dc_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val,
    output logic              byte_dc
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              vld;
        logic              dc;
    } shift_t;

    shift_t s_q, s_d;

    always_comb begin
        s_d           = s_q;
        s_d.vld       = 1'b0;
        s_d.sclk_prev = sclk_s;
        if (cs_n_s) begin
            s_d.cnt = '0;
        end else if (s_q.sclk_prev && !sclk_s) begin
            s_d.sh  = {s_q.sh[BYTE_W-2:0], sdin_s};
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CNT_W'(BYTE_W - 1)) begin
                s_d.vld = 1'b1;
                s_d.dc  = dc_s;
                s_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.sclk_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_vld = s_q.vld;
    assign byte_val = s_q.sh;
    assign byte_dc  = s_q.dc;
endmodule

// File: rtl/oled_rx_cmd.sv
module oled_rx_cmd
    import oled_rx_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    localparam int CW  = $clog2(COLS),
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld,
    input  logic [7:0]    cmd_byte,
    output logic [CW-1:0] col_start,
    output logic [CW-1:0] col_end,
    output logic [RW-1:0] row_start,
    output logic [RW-1:0] row_end,
    output logic [6:0]    contrast,
    output logic [1:0]    irange,
    output logic          col_load,
    output logic          row_load
);
    typedef struct packed {
        parse_e        st;
        logic [7:0]    tmp;
        logic [CW-1:0] cs;
        logic [CW-1:0] ce;
        logic [RW-1:0] rs;
        logic [RW-1:0] re;
        logic [6:0]    lvl;
        logic [1:0]    ir;
        logic          cload;
        logic          rload;
    } cmd_t;

    cmd_t c_q, c_d;

    function automatic logic [RW-1:0] row_clamp(input logic [7:0] v);
        if (int'(v) > ROWS - 1) return RW'(ROWS - 1);
        return v[RW-1:0];
    endfunction

    always_comb begin
        c_d       = c_q;
        c_d.cload = 1'b0;
        c_d.rload = 1'b0;
        if (cmd_vld) begin
            unique case (c_q.st)
                PS_IDLE: begin
                    case (cmd_byte)
                        OP_COLWIN: c_d.st = PS_COL_A;
                        OP_ROWWIN: c_d.st = PS_ROW_A;
                        OP_LEVEL:  c_d.st = PS_LEVEL;
                        OP_IR_Q:   c_d.ir = IR_QUARTER;
                        OP_IR_H:   c_d.ir = IR_HALF;
                        OP_IR_F:   c_d.ir = IR_FULL;
                        default:   c_d.st = PS_IDLE;
                    endcase
                end
                PS_COL_A: begin
                    c_d.tmp = cmd_byte;
                    c_d.st  = PS_COL_B;
                end
                PS_COL_B: begin
                    c_d.cs    = c_q.tmp[CW-1:0];
                    c_d.ce    = cmd_byte[CW-1:0];
                    c_d.cload = 1'b1;
                    c_d.st    = PS_IDLE;
                end
                PS_ROW_A: begin
                    c_d.tmp = cmd_byte;
                    c_d.st  = PS_ROW_B;
                end
                PS_ROW_B: begin
                    c_d.rs    = row_clamp(c_q.tmp);
                    c_d.re    = row_clamp(cmd_byte);
                    c_d.rload = 1'b1;
                    c_d.st    = PS_IDLE;
                end
                PS_LEVEL: begin
                    c_d.lvl = cmd_byte[6:0];
                    c_d.st  = PS_IDLE;
                end
                default: c_d.st = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.st  <= PS_IDLE;
            c_q.ce  <= CW'(COLS - 1);
            c_q.re  <= RW'(ROWS - 1);
            c_q.lvl <= LEVEL_RST;
            c_q.ir  <= IR_QUARTER;
        end else begin
            c_q <= c_d;
        end
    end

    assign col_start = c_q.cs;
    assign col_end   = c_q.ce;
    assign row_start = c_q.rs;
    assign row_end   = c_q.re;
    assign contrast  = c_q.lvl;
    assign irange    = c_q.ir;
    assign col_load  = c_q.cload;
    assign row_load  = c_q.rload;
endmodule

// File: rtl/oled_rx_addr.sv
module oled_rx_addr #(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    localparam int CW  = $clog2(COLS),
    localparam int RW  = $clog2(ROWS),
    localparam int AW  = $clog2(COLS * ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_vld,
    input  logic [7:0]    data_byte,
    input  logic [CW-1:0] col_start,
    input  logic [CW-1:0] col_end,
    input  logic [RW-1:0] row_start,
    input  logic [RW-1:0] row_end,
    input  logic          col_load,
    input  logic          row_load,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata
);
    typedef struct packed {
        logic [CW-1:0] cp;
        logic [RW-1:0] rp;
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    wdata;
    } ptr_t;

    ptr_t p_q, p_d;
    logic col_last, row_last;

    always_comb begin
        col_last = (p_q.cp == col_end) || (p_q.cp == CW'(COLS - 1));
        row_last = (p_q.rp == row_end) || (p_q.rp == RW'(ROWS - 1));
        p_d      = p_q;
        p_d.we   = 1'b0;
        if (col_load) p_d.cp = col_start;
        if (row_load) p_d.rp = row_start;
        if (data_vld) begin
            p_d.we    = 1'b1;
            p_d.addr  = AW'(p_q.rp) * AW'(COLS) + AW'(p_q.cp);
            p_d.wdata = data_byte;
            if (col_last) begin
                p_d.cp = col_start;
                p_d.rp = row_last ? row_start : p_q.rp + 1'b1;
            end else begin
                p_d.cp = p_q.cp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign ram_we    = p_q.we;
    assign ram_addr  = p_q.addr;
    assign ram_wdata = p_q.wdata;
endmodule

// File: rtl/oled_cmd_rx.sv
module oled_cmd_rx #(
    parameter int COLS     = 64,
    parameter int ROWS     = 80,
    parameter int SYNC_STG = 2,
    localparam int CW      = $clog2(COLS),
    localparam int RW      = $clog2(ROWS),
    localparam int AW      = $clog2(COLS * ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          sdin,
    input  logic          dc,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    output logic [CW-1:0] col_start,
    output logic [CW-1:0] col_end,
    output logic [RW-1:0] row_start,
    output logic [RW-1:0] row_end,
    output logic [6:0]    contrast,
    output logic [1:0]    irange
);
    logic [3:0] pins_s;
    logic       byte_vld, byte_dc;
    logic [7:0] byte_val;
    logic       col_load, row_load;
    logic       cmd_vld, data_vld;

    oled_rx_sync #(.N(4), .STAGES(SYNC_STG), .RST_VAL(4'b0011)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({dc, sdin, sclk, cs_n}),
        .dout (pins_s)
    );

    oled_rx_shift #(.BYTE_W(8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s[0]),
        .sclk_s  (pins_s[1]),
        .sdin_s  (pins_s[2]),
        .dc_s    (pins_s[3]),
        .byte_vld(byte_vld),
        .byte_val(byte_val),
        .byte_dc (byte_dc)
    );

    assign cmd_vld  = byte_vld && !byte_dc;
    assign data_vld = byte_vld &&  byte_dc;

    oled_rx_cmd #(.COLS(COLS), .ROWS(ROWS)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_vld  (cmd_vld),
        .cmd_byte (byte_val),
        .col_start(col_start),
        .col_end  (col_end),
        .row_start(row_start),
        .row_end  (row_end),
        .contrast (contrast),
        .irange   (irange),
        .col_load (col_load),
        .row_load (row_load)
    );

    oled_rx_addr #(.COLS(COLS), .ROWS(ROWS)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_vld (data_vld),
        .data_byte(byte_val),
        .col_start(col_start),
        .col_end  (col_end),
        .row_start(row_start),
        .row_end  (row_end),
        .col_load (col_load),
        .row_load (row_load),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .ram_wdata(ram_wdata)
    );
endmodule

// File: rtl/oled_rx_checker.sv
module oled_rx_checker #(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    localparam int CW  = $clog2(COLS),
    localparam int RW  = $clog2(ROWS),
    localparam int AW  = $clog2(COLS * ROWS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic          data_vld,
    input logic          cmd_vld,
    input logic [CW-1:0] col_start,
    input logic [CW-1:0] col_end,
    input logic [RW-1:0] row_start,
    input logic [RW-1:0] row_end,
    input logic [6:0]    contrast,
    input logic [1:0]    irange
);
    // R3: strobe lasts one cycle
    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R3: every strobe stems from a data-marked byte
    p_we_from_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(data_vld));

    // R6: stored row end never exceeds the last row
    p_row_end_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(row_end) <= ROWS - 1);

    // R8: only the three defined range codes occur
    p_irange_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irange != 2'd3);

    // R7: contrast moves only after a command byte
    p_level_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_vld) |-> $stable(contrast));

    // R9: writes land inside a well-formed column window
    p_col_in_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && col_start <= col_end) |->
        (ram_addr[CW-1:0] >= col_start && ram_addr[CW-1:0] <= col_end));

    // R9: writes land inside a well-formed row window
    p_row_in_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && row_start <= row_end) |->
        (int'(ram_addr) / COLS >= int'(row_start) &&
         int'(ram_addr) / COLS <= int'(row_end)));
endmodule

bind oled_cmd_rx oled_rx_checker #(.COLS(COLS), .ROWS(ROWS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .data_vld (data_vld),
    .cmd_vld  (cmd_vld),
    .col_start(col_start),
    .col_end  (col_end),
    .row_start(row_start),
    .row_end  (row_end),
    .contrast (contrast),
    .irange   (irange)
);

// File: tb/sim_oled_cmd_rx.sv
`timescale 1ns/1ps
module sim_oled_cmd_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b1, sdin = 1'b0, dc = 1'b0;
    logic        ram_we;
    logic [12:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [5:0]  col_start, col_end;
    logic [6:0]  row_start, row_end;
    logic [6:0]  contrast;
    logic [1:0]  irange;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [20:0] expq [$];

    int bcs = 0, bce = 63, brs = 0, bre = 79, bcol = 0, brow = 0;

    always #2 clk = ~clk;

    oled_cmd_rx u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin), .dc(dc),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .col_start(col_start), .col_end(col_end), .row_start(row_start),
        .row_end(row_end), .contrast(contrast), .irange(irange)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send_byte(input logic is_data, input logic [7:0] b);
        cs_n = 1'b0;
        dc   = is_data;
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b1; sdin = b[i]; wclk(4);
            sclk = 1'b0; wclk(4);
        end
        sclk = 1'b1; wclk(4);
        cs_n = 1'b1; wclk(6);
    endtask

    task automatic cmd(input logic [7:0] b);
        send_byte(1'b0, b);
    endtask

    task automatic data(input logic [7:0] b);
        expq.push_back({13'(brow * 64 + bcol), b});
        if (bcol == bce || bcol == 63) begin
            bcol = bcs;
            brow = (brow == bre || brow == 79) ? brs : brow + 1;
        end else begin
            bcol++;
        end
        send_byte(1'b1, b);
    endtask

    // monitor: pops expected writes
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            if (expq.size() == 0) begin
                checks++; fails++;
                $display("FAIL R3: actual unexpected write addr %0d expected none", ram_addr);
            end else begin
                logic [20:0] e;
                e = expq.pop_front();
                check("R3/R9 addr", int'(ram_addr), int'(e[20:8]));
                check("R1/R3 wdata", int'(ram_wdata), int'(e[7:0]));
            end
        end
    end

    task automatic check_cfg(input string req);
        @(negedge clk);
        check({req, " col_start"}, col_start, bcs);
        check({req, " col_end"}, col_end, bce);
        check({req, " row_start"}, row_start, brs);
        check({req, " row_end"}, row_end, bre);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wclk(3);
        @(negedge clk);
        // R4 reset values
        check("R4 ram_we", ram_we, 0);
        check_cfg("R4");
        check("R4 contrast", contrast, 'h40);
        check("R4 irange", irange, 0);
        rst_n = 1'b1;
        wclk(4);

        // R1, R3, R9: writes from origin, varied bit patterns
        data(8'hA5); data(8'h3C); data(8'h81);

        // R5/R6: window 2..4 by 1..2, then walk past both wraps (R9)
        cmd(8'h15); cmd(8'd2); cmd(8'd4);
        bcs = 2; bce = 4; bcol = 2;
        cmd(8'h75); cmd(8'd1); cmd(8'd2);
        brs = 1; bre = 2; brow = 1;
        check_cfg("R5/R6 window");
        for (int k = 0; k < 8; k++) data(8'(8'h10 + k));

        // R7 contrast uses low 7 bits
        cmd(8'h81); cmd(8'hFF);
        @(negedge clk); check("R7 contrast", contrast, 'h7F);
        cmd(8'h81); cmd(8'h12);
        @(negedge clk); check("R7 contrast", contrast, 'h12);

        // R8 current range
        cmd(8'h85); @(negedge clk); check("R8 half", irange, 1);
        cmd(8'h86); @(negedge clk); check("R8 full", irange, 2);
        cmd(8'h84); @(negedge clk); check("R8 quarter", irange, 0);

        // R11 unknown code: state unchanged, pointer continues
        cmd(8'h99);
        check_cfg("R11 window");
        check("R11 contrast", contrast, 'h12);
        check("R11 irange", irange, 0);
        data(8'h5A);

        // R10 opcode-valued byte consumed as parameter (0x81 & 0x3F = 1)
        cmd(8'h15); cmd(8'h81); cmd(8'd5);
        bcs = 1; bce = 5; bcol = 1;
        check_cfg("R10 window");
        check("R10 contrast", contrast, 'h12);

        // R6 clamp of oversize row parameters; R5 upper bits masked
        cmd(8'h75); cmd(8'd78); cmd(8'd200);
        brs = 78; bre = 79; brow = 78;
        cmd(8'h15); cmd(8'hFE); cmd(8'hFF);
        bcs = 62; bce = 63; bcol = 62;
        check_cfg("R5/R6 clamp");
        for (int k = 0; k < 5; k++) data(8'(8'hC0 + k));

        // R2 partial byte dropped on cs_n rise
        cs_n = 1'b0; dc = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; sdin = 1'b1; wclk(4);
            sclk = 1'b0; wclk(4);
        end
        sclk = 1'b1; wclk(4);
        cs_n = 1'b1; wclk(6);
        data(8'h0F);
        data(8'hF0);

        wclk(20);
        check("R3 queue drained", expq.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule